// File: doc/BRIEF.md
# Interrupt Routing Register File

This block holds the configuration that an I/O interrupt router needs for each of its input pins, and presents it to software through two memory-mapped locations. Software first stores a dword index in the index location, then reads or writes the data window to reach the internal 32-bit register that the index selects. Inside are an identification register, a read-only version and capacity register, an arbitration register and a table of 64-bit routing entries. Each entry is split into a low dword and a high dword.

The decoded fields of every entry leave the block as parallel per-pin outputs for the pin capture logic. These fields are vector, delivery-mode code, destination mode, polarity, trigger mode, mask and destination. The capture logic returns two status flags per pin: a delivery-pending flag and a remote-acceptance flag. These appear in the low dword on reads, and software writes cannot alter them. Interrupt sensing and bus messaging are outside this block.

Top module: `irq_route_regfile`

## Requirements
- R1: A write at byte offset 0x00 loads the 8-bit index, and a read there returns it in bits 7:0 with all other bits zero. Offset 0x10 is the data window onto the register the index selects. Any other offset reads zero, and writes to it do nothing.
- R2: Index 0 is the identification register. Bits 27:24 are writable, and all other bits read zero. Reset value is zero.
- R3: Index 1 is read-only. It returns 0x11 in bits 7:0 and the entry count minus one in bits 23:16, which gives 0x00170011 with 24 entries. Writes leave it unchanged.
- R4: Index 2 is the arbitration register, held in bits 27:24. A write to index 0 loads it with the same 4-bit value written to the ID. Writes to index 2 itself are ignored.
- R5: Entry n has its low dword at index 0x10+2n and its high dword at index 0x11+2n. The writable low bits are:
  - vector, bits 7:0
  - delivery-mode code, bits 10:8
  - destination mode, bit 11 (1 = logical)
  - polarity, bit 13 (1 = active low)
  - trigger, bit 15 (1 = level)
  - mask, bit 16 (1 = masked)
  Bits 31:17 read zero.
- R6: Low-dword bit 12 reads the pin's pending input, and bit 14 reads its remote-acceptance input. Writing the low dword never changes either flag.
- R7: High-dword bits 31:24 hold the 8-bit destination, whose physical ID is bits 27:24. Bits 23:0 read zero.
- R8: After reset every entry has its mask set and all other writable fields cleared. With both status inputs low, the low dword reads 0x00010000 and the high dword reads zero.
- R9: Indexes 3 to 0x0F, and indexes at or above 0x10+2*entries, read zero. Writes to them change no register.
- R10: The per-pin outputs show an entry's stored fields from the clock edge that completes the data-window write onward. A write to one entry leaves every other entry unchanged.
- R11: The delivery-mode code is stored and output exactly as written, including the reserved codes 011 and 110. The defined codes are 000 fixed, 001 lowest priority, 010 system management, 100 NMI, 101 INIT and 111 external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pinPending | input | 24 | Delivery-pending flag per pin |
| pinRemoteIrr | input | 24 | Remote-acceptance flag per pin |
| pinVector | output | 192 | 8-bit vector per pin |
| pinMode | output | 72 | 3-bit delivery-mode code per pin |
| pinDestLogical | output | 24 | Destination mode per pin |
| pinActiveLow | output | 24 | Polarity per pin |
| pinLevel | output | 24 | Trigger mode per pin |
| pinMask | output | 24 | Mask per pin |
| pinDest | output | 192 | 8-bit destination per pin |

## Verification
The bench writes all ones into dwords that contain read-only status positions. A design that let those writes through would read back the written bits rather than the pending and remote-acceptance inputs. It also writes to the arbitration and version indexes and checks both are unchanged, and confirms an ID write copies into arbitration; a design that decoded this wrongly would show a stale or overwritten value. It probes the indexes just past the table, the gap between 3 and 0x0F, and the first and last entries. An off-by-one entry decode would alias a neighbouring entry or leave the last entry unreachable. Reserved delivery-mode codes are written to confirm they pass through unchanged rather than being remapped.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int IDX_W = 8;

  // One routing entry as stored (status flags live outside)
  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       level;
    logic       activeLow;
    logic       destLogical;
    logic [2:0] mode;
    logic [7:0] vector;
  } routeEntryT;

  // Which internal register the current index selects
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ID,
    SEL_VER,
    SEL_ARB,
    SEL_LO,
    SEL_HI
  } regSelT;

  // Write strobes from control to datapath
  typedef struct packed {
    logic idWe;
    logic loWe;
    logic hiWe;
  } wrStrobeT;

endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NPIN     = 24,
  parameter int IDX_OFF  = 8'h00,
  parameter int WIN_OFF  = 8'h10,
  localparam int ENT_W   = (NPIN > 1) ? $clog2(NPIN) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWe,
  input  logic [7:0]       busAddr,
  input  logic [31:0]      busWdata,
  output logic [IDX_W-1:0] indexVal,
  output regSelT           regSel,
  output logic [ENT_W-1:0] entrySel,
  output wrStrobeT         strobes
);

  localparam logic [IDX_W-1:0] TABLE_BASE = 8'h10;
  localparam int               TABLE_END  = 16 + 2 * NPIN;

  logic [IDX_W-1:0] indexQ;
  logic [IDX_W-1:0] tableOff;
  logic [IDX_W-2:0] entryFull;
  logic             inTable;
  logic             winWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) indexQ <= '0;
    else if (busWe && busAddr == IDX_OFF[7:0]) indexQ <= busWdata[IDX_W-1:0];
  end

  assign indexVal  = indexQ;
  assign tableOff  = indexQ - TABLE_BASE;
  assign entryFull = tableOff[IDX_W-1:1];
  assign inTable   = (indexQ >= TABLE_BASE) && (int'(indexQ) < TABLE_END);

  always_comb begin
    regSel   = SEL_NONE;
    entrySel = '0;
    if (inTable) begin
      regSel   = tableOff[0] ? SEL_HI : SEL_LO;
      entrySel = entryFull[ENT_W-1:0];
    end else begin
      case (indexQ)
        8'h00:   regSel = SEL_ID;
        8'h01:   regSel = SEL_VER;
        8'h02:   regSel = SEL_ARB;
        default: regSel = SEL_NONE;
      endcase
    end
  end

  assign winWrite     = busWe && (busAddr == WIN_OFF[7:0]);
  assign strobes.idWe = winWrite && (regSel == SEL_ID);
  assign strobes.loWe = winWrite && (regSel == SEL_LO);
  assign strobes.hiWe = winWrite && (regSel == SEL_HI);

  // R10: at most one internal register written per bus write
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.idWe, strobes.loWe, strobes.hiWe}));

  // R9: table strobes never select an entry beyond the table
  p_entry_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loWe || strobes.hiWe) |-> (int'(entrySel) < NPIN));

  // R1: an index-register write does not also write an internal register
  p_index_no_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == IDX_OFF[7:0]) |-> !(strobes.idWe || strobes.loWe || strobes.hiWe));

endmodule

// File: rtl/irq_route_dpath.sv
module irq_route_dpath
  import irq_route_pkg::*;
#(
  parameter int NPIN    = 24,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int ENT_W  = (NPIN > 1) ? $clog2(NPIN) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobeT         strobes,
  input  regSelT           regSel,
  input  logic [ENT_W-1:0] entrySel,
  input  logic [31:0]      wdata,
  input  logic [NPIN-1:0]  pinPending,
  input  logic [NPIN-1:0]  pinRemoteIrr,
  output logic [31:0]      rdata,
  output routeEntryT       entries [NPIN]
);

  localparam logic [7:0] MAX_ENTRY = 8'(NPIN - 1);

  logic [3:0] idQ;
  logic [3:0] arbQ;
  routeEntryT entryQ [NPIN];

  // ID write also loads arbitration; index 2 has no write path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idQ  <= '0;
      arbQ <= '0;
    end else if (strobes.idWe) begin
      idQ  <= wdata[27:24];
      arbQ <= wdata[27:24];
    end
  end

  for (genvar e = 0; e < NPIN; e++) begin : g_entry
    logic hit;
    assign hit = (int'(entrySel) == e);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entryQ[e]      <= '0;
        entryQ[e].mask <= 1'b1;
      end else begin
        if (strobes.loWe && hit) begin
          entryQ[e].vector      <= wdata[7:0];
          entryQ[e].mode        <= wdata[10:8];
          entryQ[e].destLogical <= wdata[11];
          entryQ[e].activeLow   <= wdata[13];
          entryQ[e].level       <= wdata[15];
          entryQ[e].mask        <= wdata[16];
        end
        if (strobes.hiWe && hit) entryQ[e].dest <= wdata[31:24];
      end
    end

    assign entries[e] = entryQ[e];
  end

  routeEntryT rdEnt;
  assign rdEnt = entryQ[entrySel];

  always_comb begin
    case (regSel)
      SEL_ID:  rdata = {4'h0, idQ, 24'h0};
      SEL_VER: rdata = {8'h0, MAX_ENTRY, 8'h0, VERSION};
      SEL_ARB: rdata = {4'h0, arbQ, 24'h0};
      SEL_LO:  rdata = {15'h0, rdEnt.mask, rdEnt.level, pinRemoteIrr[entrySel],
                        rdEnt.activeLow, pinPending[entrySel], rdEnt.destLogical,
                        rdEnt.mode, rdEnt.vector};
      SEL_HI:  rdata = {rdEnt.dest, 24'h0};
      default: rdata = '0;
    endcase
  end

  // R4: arbitration changes only through an ID write
  p_arb_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.idWe |=> $stable(arbQ));

  // R4: after an ID write, arbitration equals the ID
  p_arb_follow_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.idWe |=> (arbQ == idQ));

  // R10: entry 0 holds its mask unless its low dword is written
  p_entry0_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loWe && entrySel == '0) |=> $stable(entryQ[0].mask));

endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
  import irq_route_pkg::*;
#(
  parameter int NPIN    = 24,
  parameter int IDX_OFF = 8'h00,
  parameter int WIN_OFF = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [NPIN-1:0]   pinPending,
  input  logic [NPIN-1:0]   pinRemoteIrr,
  output logic [NPIN*8-1:0] pinVector,
  output logic [NPIN*3-1:0] pinMode,
  output logic [NPIN-1:0]   pinDestLogical,
  output logic [NPIN-1:0]   pinActiveLow,
  output logic [NPIN-1:0]   pinLevel,
  output logic [NPIN-1:0]   pinMask,
  output logic [NPIN*8-1:0] pinDest
);

  localparam int ENT_W = (NPIN > 1) ? $clog2(NPIN) : 1;

  logic [IDX_W-1:0] indexVal;
  regSelT           regSel;
  logic [ENT_W-1:0] entrySel;
  wrStrobeT         strobes;
  logic [31:0]      winRdata;
  routeEntryT       entries [NPIN];

  irq_route_ctrl #(.NPIN(NPIN), .IDX_OFF(IDX_OFF), .WIN_OFF(WIN_OFF)) i_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .indexVal(indexVal), .regSel(regSel), .entrySel(entrySel), .strobes(strobes)
  );

  irq_route_dpath #(.NPIN(NPIN)) i_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regSel(regSel), .entrySel(entrySel),
    .wdata(busWdata), .pinPending(pinPending), .pinRemoteIrr(pinRemoteIrr),
    .rdata(winRdata), .entries(entries)
  );

  always_comb begin
    if (busAddr == IDX_OFF[7:0])      busRdata = {{(32-IDX_W){1'b0}}, indexVal};
    else if (busAddr == WIN_OFF[7:0]) busRdata = winRdata;
    else                              busRdata = '0;
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_out
    assign pinVector[p*8 +: 8] = entries[p].vector;
    assign pinMode[p*3 +: 3]   = entries[p].mode;
    assign pinDestLogical[p]   = entries[p].destLogical;
    assign pinActiveLow[p]     = entries[p].activeLow;
    assign pinLevel[p]         = entries[p].level;
    assign pinMask[p]          = entries[p].mask;
    assign pinDest[p*8 +: 8]   = entries[p].dest;
  end

endmodule

// File: tb/test_irq_route_regfile.sv
module test_irq_route_regfile;

  localparam int NPIN = 24;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWe = 1'b0;
  logic [7:0]        busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic [NPIN-1:0]   pinPending = '0;
  logic [NPIN-1:0]   pinRemoteIrr = '0;
  logic [NPIN*8-1:0] pinVector;
  logic [NPIN*3-1:0] pinMode;
  logic [NPIN-1:0]   pinDestLogical;
  logic [NPIN-1:0]   pinActiveLow;
  logic [NPIN-1:0]   pinLevel;
  logic [NPIN-1:0]   pinMask;
  logic [NPIN*8-1:0] pinDest;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  irq_route_regfile #(.NPIN(NPIN)) i_irq_route_regfile (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .pinPending(pinPending), .pinRemoteIrr(pinRemoteIrr),
    .pinVector(pinVector), .pinMode(pinMode), .pinDestLogical(pinDestLogical),
    .pinActiveLow(pinActiveLow), .pinLevel(pinLevel), .pinMask(pinMask),
    .pinDest(pinDest)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    busAddr = addr; busWdata = data; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busAddr = 8'hFF;
  endtask

  task automatic busRead(input logic [7:0] addr, output logic [31:0] data);
    @(negedge clk);
    busAddr = addr;
    #1 data = busRdata;
  endtask

  task automatic regWrite(input logic [7:0] idx, input logic [31:0] data);
    busWrite(8'h00, {24'h0, idx});
    busWrite(8'h10, data);
  endtask

  task automatic regRead(input logic [7:0] idx, output logic [31:0] data);
    busWrite(8'h00, {24'h0, idx});
    busRead(8'h10, data);
  endtask

  task automatic testReset();
    logic [31:0] v;
    regRead(8'h00, v); check("R2 id reset", v, 32'h0);
    regRead(8'h01, v); check("R3 version", v, 32'h00170011);
    regRead(8'h02, v); check("R4 arb reset", v, 32'h0);
    regRead(8'h10, v); check("R8 entry0 lo reset", v, 32'h00010000);
    regRead(8'h3E, v); check("R8 entry23 lo reset", v, 32'h00010000);
    regRead(8'h3F, v); check("R8 entry23 hi reset", v, 32'h0);
    check("R8 mask outputs", {8'h0, pinMask}, {8'h0, {NPIN{1'b1}}});
  endtask

  task automatic testIndex();
    logic [31:0] v;
    busWrite(8'h00, 32'hFFFF_FF2A);
    busRead(8'h00, v); check("R1 index readback", v, 32'h0000002A);
    busRead(8'h04, v); check("R1 other offset zero", v, 32'h0);
    busWrite(8'h04, 32'h0000_0011);
    busRead(8'h00, v); check("R1 other offset write ignored", v, 32'h0000002A);
  endtask

  task automatic testIdArb();
    logic [31:0] v;
    regWrite(8'h00, 32'hFFFF_FFFF);
    regRead(8'h00, v); check("R2 id write", v, 32'h0F000000);
    regRead(8'h02, v); check("R4 arb loaded by id", v, 32'h0F000000);
    regWrite(8'h02, 32'h0000_0000);
    regRead(8'h02, v); check("R4 arb write ignored", v, 32'h0F000000);
    regWrite(8'h00, 32'h0500_0000);
    regRead(8'h02, v); check("R4 arb follows id", v, 32'h05000000);
    regWrite(8'h01, 32'h0);
    regRead(8'h01, v); check("R3 version read-only", v, 32'h00170011);
  endtask

  task automatic testEntryLo();
    logic [31:0] v;
    regWrite(8'h1A, 32'hFFFF_FFFF);   // entry 5 low
    regRead(8'h1A, v); check("R5 lo writable bits", v, 32'h0001AFFF);
    check("R10 vector out", {24'h0, pinVector[5*8 +: 8]}, 32'hFF);
    check("R10 mode out", {29'h0, pinMode[5*3 +: 3]}, 32'h7);
    check("R10 flag outs", {28'h0, pinDestLogical[5], pinActiveLow[5], pinLevel[5], pinMask[5]}, 32'hF);
    check("R10 neighbour untouched", {31'h0, pinMask[4]}, 32'h1);
    regRead(8'h18, v); check("R10 entry4 untouched", v, 32'h00010000);
  endtask

  task automatic testStatus();
    logic [31:0] v;
    pinPending[5] = 1'b1; pinRemoteIrr[5] = 1'b1;
    regRead(8'h1A, v); check("R6 status visible", v, 32'h0001FFFF);
    regWrite(8'h1A, 32'h0);
    regRead(8'h1A, v); check("R6 status survives write", v, 32'h00005000);
    check("R6 mask cleared out", {31'h0, pinMask[5]}, 32'h0);
    pinPending[5] = 1'b0; pinRemoteIrr[5] = 1'b0;
    regRead(8'h1A, v); check("R6 status follows input", v, 32'h0);
  endtask

  task automatic testEntryHi();
    logic [31:0] v;
    regWrite(8'h3F, 32'hFFFF_FFFF);   // entry 23 high
    regRead(8'h3F, v); check("R7 hi dest", v, 32'hFF000000);
    check("R7 dest out", {24'h0, pinDest[23*8 +: 8]}, 32'hFF);
    regWrite(8'h11, 32'h0A00_0000);   // entry 0 high
    check("R7 physical id out", {24'h0, pinDest[0 +: 8]}, 32'h0A);
    regRead(8'h3D, v); check("R10 entry22 hi untouched", v, 32'h0);
  endtask

  task automatic testUnimpl();
    logic [31:0] v;
    regRead(8'h03, v); check("R9 index 3 zero", v, 32'h0);
    regRead(8'h0F, v); check("R9 index 0F zero", v, 32'h0);
    regRead(8'h40, v); check("R9 past table zero", v, 32'h0);
    regWrite(8'h40, 32'h0);
    regWrite(8'h41, 32'h0);
    regRead(8'h3F, v); check("R9 write past table no effect hi", v, 32'hFF000000);
    regRead(8'h10, v); check("R9 write past table no effect lo", v, 32'h00010000);
    regWrite(8'h07, 32'hFFFF_FFFF);
    regRead(8'h00, v); check("R9 gap write no effect", v, 32'h05000000);
  endtask

  task automatic testModes();
    logic [31:0] v;
    regWrite(8'h12, 32'h0000_0320);   // entry 1, reserved code 011
    check("R11 reserved 011", {29'h0, pinMode[3 +: 3]}, 32'h3);
    regWrite(8'h12, 32'h0000_0620);   // reserved code 110
    check("R11 reserved 110", {29'h0, pinMode[3 +: 3]}, 32'h6);
    regRead(8'h12, v); check("R11 readback", v, 32'h00000620);
    regWrite(8'h12, 32'h0000_0420);   // NMI code
    check("R11 nmi code", {29'h0, pinMode[3 +: 3]}, 32'h4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIndex();
    testIdArb();
    testEntryLo();
    testStatus();
    testEntryHi();
    testUnimpl();
    testModes();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule